// File: doc/BRIEF.md
# Dual-Port Memory Collision Flagger

This block sits beside a synchronous dual-port memory and watches the accesses that both ports make. On every clock edge it captures each port's enable, write select and internal address. A collision is a cycle in which both ports are enabled, both use the same address, and at least one of them writes. For each collision it drives an active-low flag on the port whose data is at risk. When the other port writes, the reading port is flagged. When both ports write, both are flagged.

Both ports run on one clock. A skew mode input selects the flag latency. With closely aligned port timing, both flags follow the same short path. With skewed timing, the leading port's flag takes one extra cycle and the trailing port keeps the short path. A lead select input names the leading port. The addresses given to the block are the memory's internal registered addresses. Any address-counter qualification happens before this block. Output enable plays no part in detection.

The interface uses plain pins only. The block carries no data stream, so it has no valid/ready handshake and never applies back-pressure. An access is offered for one cycle and always taken.

Top module: `dpm_collision_flagger`

## Requirements
- R1: When both ports are enabled, both read (write select 0), and both use the same address, neither flag asserts.
- R2: When port A reads and port B writes the same address, only `a_coll_n` goes low.
- R3: When port B reads and port A writes the same address, only `b_coll_n` goes low.
- R4: When both ports write the same address, both flags go low.
- R5: An access counts only if its port's enable is 1 at the sampling edge. Accesses to different addresses never assert a flag.
- R6: With `skew_mode`=0, both flags follow the short path. A collision sampled at edge N drives the flag low after edge N+2, and the flag returns high after edge N+3.
- R7: With `skew_mode`=1, the leading port (`lead_sel`=0 means port A, 1 means port B) takes the long path. Its flag goes low after edge N+3 and high after edge N+4. The trailing port keeps the short path of R6.
- R8: Each collision yields exactly one low cycle per flagged port. Collisions sampled on consecutive edges give flag pulses on consecutive cycles.
- R9: Synchronous reset (`rst`=1 at an edge) clears every pipeline stage and drives both flags high from that edge on. No collision sampled before that edge produces a flag afterwards.
- R10: `skew_mode` and `lead_sel` are sampled at the same edge as the access. Each collision keeps the latency chosen at its own sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock of both ports |
| rst | input | 1 | Synchronous reset, active high |
| skew_mode | input | 1 | 0 = aligned timing, 1 = skewed timing |
| lead_sel | input | 1 | Leading port in skewed mode: 0 = A, 1 = B |
| a_en | input | 1 | Port A access enable |
| a_wr | input | 1 | Port A write select (1 = write) |
| a_addr | input | AW | Port A internal address |
| b_en | input | 1 | Port B access enable |
| b_wr | input | 1 | Port B write select (1 = write) |
| b_addr | input | AW | Port B internal address |
| a_coll_n | output | 1 | Port A collision flag, active low |
| b_coll_n | output | 1 | Port B collision flag, active low |

## Verification
The bound assertions check on every cycle that each flag is low exactly when a qualifying access, seen three or four edges earlier, calls for it on the selected path. They also check that reset forces both flags high. The benchmark scenarios show the latency split between the leading and trailing ports, the handling of mode changes between adjacent collisions, and a collision that is in flight when reset arrives. Constrained random traffic on a small address range mixes reads, writes and enables so that every port-pairing case occurs many times.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  // Leading-port encoding used by lead_sel.
  typedef enum logic {
    PORT_A_LEADS = 1'b0,
    PORT_B_LEADS = 1'b1
  } lead_e;

  // Per-port flag request: collision seen, and whether it takes the long path.
  typedef struct packed {
    logic hit;
    logic slow;
  } flag_req_t;

  localparam int unsigned NUM_PORTS = 2;
endpackage

// File: rtl/dpc_port_reg.sv
// Captures one port's access qualifiers on the clock edge.
module dpc_port_reg #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  output logic          en_q,
  output logic          wr_q,
  output logic [AW-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en_i;
      wr_q   <= wr_i;
      addr_q <= addr_i;
    end
  end
endmodule

// File: rtl/dpc_hit_logic.sv
// Decides which port sees a collision and which latency path it takes.
module dpc_hit_logic
  import dpc_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          a_en,
  input  logic          a_wr,
  input  logic [AW-1:0] a_addr,
  input  logic          b_en,
  input  logic          b_wr,
  input  logic [AW-1:0] b_addr,
  input  logic          skew,
  input  lead_e         lead,
  output flag_req_t     req_a,
  output flag_req_t     req_b
);
  logic same_loc;

  always_comb begin
    same_loc   = a_en && b_en && (a_addr == b_addr);
    // A port is at risk when the opposite port writes the shared location.
    req_a.hit  = same_loc && b_wr;
    req_b.hit  = same_loc && a_wr;
    req_a.slow = skew && (lead == PORT_A_LEADS);
    req_b.slow = skew && (lead == PORT_B_LEADS);
  end
endmodule

// File: rtl/dpc_flag_delay.sv
// Two- or three-stage delay from request to registered active-low flag.
module dpc_flag_delay
  import dpc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  flag_req_t req_i,
  output logic      flag_n_o
);
  flag_req_t s1_q;
  logic      s2_q;
  logic      fire;

  always_comb fire = (s1_q.hit && !s1_q.slow) || s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q     <= '0;
      s2_q     <= 1'b0;
      flag_n_o <= 1'b1;
    end else begin
      s1_q     <= req_i;
      s2_q     <= s1_q.hit && s1_q.slow;
      flag_n_o <= !fire;
    end
  end
endmodule

// File: rtl/dpm_collision_flagger.sv
module dpm_collision_flagger
  import dpc_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          skew_mode,
  input  logic          lead_sel,
  input  logic          a_en,
  input  logic          a_wr,
  input  logic [AW-1:0] a_addr,
  input  logic          b_en,
  input  logic          b_wr,
  input  logic [AW-1:0] b_addr,
  output logic          a_coll_n,
  output logic          b_coll_n
);
  logic [NUM_PORTS-1:0]         en_in, wr_in, en_q, wr_q;
  logic [NUM_PORTS-1:0][AW-1:0] addr_in, addr_q;
  logic                         skew_q;
  lead_e                        lead_q;
  flag_req_t [NUM_PORTS-1:0]    req;
  logic [NUM_PORTS-1:0]         flag_n;

  assign en_in   = {b_en, a_en};
  assign wr_in   = {b_wr, a_wr};
  assign addr_in = {b_addr, a_addr};

  always_ff @(posedge clk) begin
    if (rst) begin
      skew_q <= 1'b0;
      lead_q <= PORT_A_LEADS;
    end else begin
      skew_q <= skew_mode;
      lead_q <= lead_e'(lead_sel);
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    dpc_port_reg #(.AW(AW)) u_reg (
      .clk    (clk),
      .rst    (rst),
      .en_i   (en_in[p]),
      .wr_i   (wr_in[p]),
      .addr_i (addr_in[p]),
      .en_q   (en_q[p]),
      .wr_q   (wr_q[p]),
      .addr_q (addr_q[p])
    );

    dpc_flag_delay u_dly (
      .clk      (clk),
      .rst      (rst),
      .req_i    (req[p]),
      .flag_n_o (flag_n[p])
    );
  end

  dpc_hit_logic #(.AW(AW)) u_hit (
    .a_en   (en_q[0]),
    .a_wr   (wr_q[0]),
    .a_addr (addr_q[0]),
    .b_en   (en_q[1]),
    .b_wr   (wr_q[1]),
    .b_addr (addr_q[1]),
    .skew   (skew_q),
    .lead   (lead_q),
    .req_a  (req[0]),
    .req_b  (req[1])
  );

  assign a_coll_n = flag_n[0];
  assign b_coll_n = flag_n[1];
endmodule

// File: rtl/dpc_collision_chk.sv
module dpc_collision_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          skew_mode,
  input logic          lead_sel,
  input logic          a_en,
  input logic          a_wr,
  input logic [AW-1:0] a_addr,
  input logic          b_en,
  input logic          b_wr,
  input logic [AW-1:0] b_addr,
  input logic          a_coll_n,
  input logic          b_coll_n
);
  logic [2:0] warm;
  logic       shared, a_risk, b_risk, a_long, b_long;

  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 3'd4) warm <= warm + 3'd1;
  end

  // Port-level view of the collision rule (R1-style cases below).
  assign shared = a_en && b_en && (a_addr == b_addr);
  assign a_risk = shared && b_wr;
  assign b_risk = shared && a_wr;
  assign a_long = skew_mode && !lead_sel;
  assign b_long = skew_mode && lead_sel;

  // R2, R6, R7: port A flag low exactly when its cause appeared on the chosen path
  p_a_flag_cause_r2: assert property (@(posedge clk) disable iff (rst || warm != 3'd4)
    !a_coll_n |-> (($past(a_risk,3) && !$past(a_long,3)) || ($past(a_risk,4) && $past(a_long,4))));
  p_a_flag_due_r7: assert property (@(posedge clk) disable iff (rst || warm != 3'd4)
    (($past(a_risk,3) && !$past(a_long,3)) || ($past(a_risk,4) && $past(a_long,4))) |-> !a_coll_n);
  // R3, R6, R7: same for port B
  p_b_flag_cause_r3: assert property (@(posedge clk) disable iff (rst || warm != 3'd4)
    !b_coll_n |-> (($past(b_risk,3) && !$past(b_long,3)) || ($past(b_risk,4) && $past(b_long,4))));
  p_b_flag_due_r6: assert property (@(posedge clk) disable iff (rst || warm != 3'd4)
    (($past(b_risk,3) && !$past(b_long,3)) || ($past(b_risk,4) && $past(b_long,4))) |-> !b_coll_n);
  // R9: reset drives both flags inactive
  p_reset_idle_r9: assert property (@(posedge clk) rst |=> (a_coll_n && b_coll_n));
endmodule

bind dpm_collision_flagger dpc_collision_chk #(.AW(AW)) u_chk (.*);

// File: tb/dpm_collision_flagger_tb.sv
module dpm_collision_flagger_tb;
  localparam int unsigned AW = 8;

  logic          clk = 1'b0;
  logic          rst, skew_mode, lead_sel;
  logic          a_en, a_wr, b_en, b_wr;
  logic [AW-1:0] a_addr, b_addr;
  logic          a_coll_n, b_coll_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Model history: index 0 is the access driven most recently.
  logic [3:0]  h_a, h_b, h_la, h_lb;
  string       h_tag [4];

  always #2 clk = ~clk;

  dpm_collision_flagger #(.AW(AW)) u_dut (.*);

  // R1-style rule from R2, R3, R4, R5: returns {b_flag, a_flag}
  function automatic logic [1:0] risk(input logic ea, wa, input logic [AW-1:0] aa,
                                      input logic eb, wb, input logic [AW-1:0] ab);
    logic same;
    same = ea && eb && (aa == ab);
    return {same && wa, same && wb};
  endfunction

  task automatic check_flags();
    logic ea, eb;
    ea = (h_a[2] && !h_la[2]) || (h_a[3] && h_la[3]);
    eb = (h_b[2] && !h_lb[2]) || (h_b[3] && h_lb[3]);
    checks += 2;
    if (a_coll_n !== !ea) begin
      errors++;
      $display("FAIL %s port A flag: actual %b expected %b", h_tag[2], a_coll_n, !ea);
    end
    if (b_coll_n !== !eb) begin
      errors++;
      $display("FAIL %s port B flag: actual %b expected %b", h_tag[2], b_coll_n, !eb);
    end
  endtask

  task automatic step(input logic r, ea, wa, input logic [AW-1:0] aa,
                      input logic eb, wb, input logic [AW-1:0] ab,
                      input logic md, ld, input string tag);
    logic [1:0] rk;
    @(negedge clk);
    check_flags();
    rst = r; a_en = ea; a_wr = wa; a_addr = aa;
    b_en = eb; b_wr = wb; b_addr = ab; skew_mode = md; lead_sel = ld;
    rk = risk(ea, wa, aa, eb, wb, ab);
    if (r) begin
      h_a = '0; h_b = '0; h_la = '0; h_lb = '0;
    end else begin
      h_a  = {h_a[2:0],  rk[0]};
      h_b  = {h_b[2:0],  rk[1]};
      h_la = {h_la[2:0], md && !ld};
      h_lb = {h_lb[2:0], md && ld};
    end
    h_tag[3] = h_tag[2]; h_tag[2] = h_tag[1]; h_tag[1] = h_tag[0]; h_tag[0] = tag;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0, 0, 0, '0, 0, 0, tag);
  endtask

  initial begin
    rst = 1'b1; skew_mode = 0; lead_sel = 0;
    a_en = 0; a_wr = 0; a_addr = '0; b_en = 0; b_wr = 0; b_addr = '0;
    h_a = '0; h_b = '0; h_la = '0; h_lb = '0;
    for (int i = 0; i < 4; i++) h_tag[i] = "R9";
    for (int i = 0; i < 3; i++) step(1, 0, 0, '0, 0, 0, '0, 0, 0, "R9");
    idle(4, "R9");
    // Directed port-pairing cases, aligned mode
    step(0, 1, 0, 8'h11, 1, 0, 8'h11, 0, 0, "R1"); idle(4, "R1");
    step(0, 1, 0, 8'h22, 1, 1, 8'h22, 0, 0, "R2"); idle(4, "R2");
    step(0, 1, 1, 8'h33, 1, 0, 8'h33, 0, 0, "R3"); idle(4, "R3");
    step(0, 1, 1, 8'h44, 1, 1, 8'h44, 0, 0, "R4"); idle(4, "R6");
    step(0, 0, 1, 8'h55, 1, 1, 8'h55, 0, 0, "R5");
    step(0, 1, 1, 8'h56, 1, 1, 8'h57, 0, 0, "R5"); idle(4, "R5");
    // Skewed mode, each leading port
    step(0, 1, 1, 8'h60, 1, 1, 8'h60, 1, 0, "R7"); idle(5, "R7");
    step(0, 1, 1, 8'h61, 1, 1, 8'h61, 1, 1, "R7"); idle(5, "R7");
    // Back-to-back pulses
    for (int i = 0; i < 3; i++) step(0, 1, 1, 8'h70, 1, 0, 8'h70, 0, 0, "R8");
    idle(5, "R8");
    // Mode change between adjacent collisions
    step(0, 1, 0, 8'h80, 1, 1, 8'h80, 1, 0, "R10");
    step(0, 1, 0, 8'h80, 1, 1, 8'h80, 0, 0, "R10");
    step(0, 1, 0, 8'h80, 1, 1, 8'h80, 1, 0, "R10");
    idle(5, "R10");
    // Reset with a collision in flight
    step(0, 1, 1, 8'h90, 1, 1, 8'h90, 1, 1, "R9");
    step(1, 0, 0, '0, 0, 0, '0, 0, 0, "R9");
    idle(6, "R9");
    // Constrained random: small address range to force frequent matches
    void'($urandom(32'd2024));
    for (int i = 0; i < 3000; i++) begin
      logic md;
      md = (i / 200) % 2;
      step(0, $urandom_range(0, 3) != 0, $urandom_range(0, 1), AW'($urandom_range(0, 3)),
           $urandom_range(0, 3) != 0, $urandom_range(0, 1), AW'($urandom_range(0, 3)),
           md, $urandom_range(0, 1), md ? "R7" : "R6");
    end
    idle(5, "R8");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired: actual hung expected done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule